// File: doc/BRIEF.md
# Write-Protect Unlock Sequence Detector

This block stands between a memory's bus-side write decoder and its array-write path. Every write request it sees carries an address and a data byte. The array is locked by default. Writes reach the array only after three particular command writes arrive back to back. The three command writes are swallowed and are never forwarded as data.

Once the sequence has been seen, the gate opens. Each following write is forwarded, one cycle later, with its address and data unchanged. The gate closes when the page loader reports that the page load has ended. It also closes when the byte-load timer reports that the gap between two writes exceeded its window. A write that arrives out of order returns the detector to the locked state.

A two-bit stage output shows how far the unlock has progressed.

Top module: `wp_unlock_gate`

## Requirements
- R1: After reset, `prot_stage` is 0, `unlocked` is 0, and both `pass_vld` and `swallow` are 0.
- R2: `prot_stage` is encoded as follows: 0 means locked, 1 means the first key has been seen, 2 means the second key has been seen, and 3 means open. `unlocked` is 1 exactly when `prot_stage` is 3.
- R3: In stage 0, a write of data 0xAA to address 0x5555 moves the stage to 1. The write is swallowed.
- R4: In stage 1, a write of 0x55 to 0x2AAA moves the stage to 2. In stage 2, a write of 0xA0 to 0x5555 moves the stage to 3. Both writes are swallowed.
- R5: In stages 0 to 2, any write other than the expected key write leaves or returns the stage at 0. The write is swallowed and nothing is forwarded.
- R6: In stage 3, each write is forwarded. `pass_vld` is high in the cycle after the request, `pass_addr` and `pass_data` equal the request's address and data, and the stage stays 3.
- R7: A `win_expire` pulse returns the stage to 0 on the next cycle, from any stage. A write in the same cycle is swallowed.
- R8: A `page_closed` pulse returns the stage to 0 on the next cycle, from any stage. A write in the same cycle is swallowed.
- R9: Each write request produces exactly one of `pass_vld` or `swallow`, one cycle after the request. A cycle without a request produces neither.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_req | input | 1 | One-cycle write request |
| wr_addr | input | 15 | Address of the write |
| wr_data | input | 8 | Data of the write |
| win_expire | input | 1 | Pulse from the byte-load timer: the window between writes lapsed |
| page_closed | input | 1 | Pulse from the page loader: the current page load has ended |
| unlocked | output | 1 | High while writes are forwarded |
| prot_stage | output | 2 | Unlock progress, encoded as in R2 |
| pass_vld | output | 1 | A forwarded write is presented |
| pass_addr | output | 15 | Forwarded address |
| pass_data | output | 8 | Forwarded data |
| swallow | output | 1 | The previous cycle's write was consumed and not forwarded |

## Verification
The detector is driven with several kinds of input sequence:
- A clean three-key sequence, followed by data writes. This separates forwarding from swallowing and shows that addresses and data are carried through intact.
- Near misses: a correct first key followed by a wrong address, a wrong final data byte, or a repeated first key. These show that the exact step order is enforced and that a broken sequence does not resynchronise partway.
- Timer and page-close pulses, both alone and in the same cycle as a write. These show that relocking takes priority over a write arriving in the same cycle.

Idle cycles between operations check that no output appears without a request.

// File: rtl/wp_unlock_pkg.sv
package wp_unlock_pkg;
   typedef enum logic [1:0] {
      ST_LOCKED = 2'd0,
      ST_KEY1   = 2'd1,
      ST_KEY2   = 2'd2,
      ST_OPEN   = 2'd3
   } stage_t;
endpackage

// File: rtl/wp_key_match.sv
module wp_key_match #(
   parameter int          ADDR_W   = 15,
   parameter int          DATA_W   = 8,
   parameter int          KEY_BITS = 15,
   parameter logic [14:0] KEY_ADDR_A = 15'h5555,
   parameter logic [14:0] KEY_ADDR_B = 15'h2AAA,
   parameter logic [7:0]  KEY_D1 = 8'hAA,
   parameter logic [7:0]  KEY_D2 = 8'h55,
   parameter logic [7:0]  KEY_D3 = 8'hA0
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] data,
   output logic              hit1,
   output logic              hit2,
   output logic              hit3
);
   localparam int CMP_W = (KEY_BITS < ADDR_W) ? KEY_BITS : ADDR_W;

   initial begin
      if (KEY_BITS < 1 || KEY_BITS > ADDR_W)
         $error("wp_key_match: KEY_BITS must be in 1..ADDR_W");
      if (DATA_W != 8)
         $error("wp_key_match: key data bytes need DATA_W of 8");
   end

   logic at_a, at_b;

   generate
      if (CMP_W == ADDR_W) begin : g_full
         assign at_a = (addr == ADDR_W'(KEY_ADDR_A));
         assign at_b = (addr == ADDR_W'(KEY_ADDR_B));
      end else begin : g_partial
         logic [CMP_W-1:0] ka, kb;
         assign ka   = KEY_ADDR_A[CMP_W-1:0];
         assign kb   = KEY_ADDR_B[CMP_W-1:0];
         assign at_a = (addr[CMP_W-1:0] == ka);
         assign at_b = (addr[CMP_W-1:0] == kb);
      end
   endgenerate

   assign hit1 = at_a && (data == DATA_W'(KEY_D1));
   assign hit2 = at_b && (data == DATA_W'(KEY_D2));
   assign hit3 = at_a && (data == DATA_W'(KEY_D3));
endmodule

// File: rtl/wp_seq_fsm.sv
module wp_seq_fsm
   import wp_unlock_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  logic   wr_req,
   input  logic   hit1,
   input  logic   hit2,
   input  logic   hit3,
   input  logic   win_expire,
   input  logic   page_closed,
   output stage_t stage,
   output logic   fwd
);
   stage_t nxt;
   logic   relock;

   assign relock = win_expire || page_closed;
   assign fwd    = wr_req && !relock && (stage == ST_OPEN);

   always_comb begin
      nxt = stage;
      if (relock) begin
         nxt = ST_LOCKED;
      end else if (wr_req) begin
         unique case (stage)
            ST_LOCKED: nxt = hit1 ? ST_KEY1 : ST_LOCKED;
            ST_KEY1:   nxt = hit2 ? ST_KEY2 : ST_LOCKED;
            ST_KEY2:   nxt = hit3 ? ST_OPEN : ST_LOCKED;
            ST_OPEN:   nxt = ST_OPEN;
            default:   nxt = ST_LOCKED;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) stage <= ST_LOCKED;
      else        stage <= nxt;
   end

   // R3 / R4: each step forward needs a request in the preceding cycle
   a_r4_step_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
      (stage != ST_LOCKED && stage != $past(stage)) |-> $past(wr_req));

   // R4: the open stage is entered only from the second-key stage
   a_r4_open_from_key2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stage == ST_OPEN) |-> ($past(stage) == ST_KEY2));

   // R7: a lapsed window always relocks
   a_r7_expire_relock: assert property (@(posedge clk) disable iff (!rst_n)
      win_expire |=> (stage == ST_LOCKED));

   // R8: a closed page always relocks
   a_r8_close_relock: assert property (@(posedge clk) disable iff (!rst_n)
      page_closed |=> (stage == ST_LOCKED));
endmodule

// File: rtl/wp_fwd_reg.sv
module wp_fwd_reg #(
   parameter int ADDR_W = 15,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_req,
   input  logic              fwd,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] data,
   output logic              pass_vld,
   output logic [ADDR_W-1:0] pass_addr,
   output logic [DATA_W-1:0] pass_data,
   output logic              swallow
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pass_vld  <= 1'b0;
         swallow   <= 1'b0;
         pass_addr <= '0;
         pass_data <= '0;
      end else begin
         pass_vld <= wr_req && fwd;
         swallow  <= wr_req && !fwd;
         if (wr_req && fwd) begin
            pass_addr <= addr;
            pass_data <= data;
         end
      end
   end

   // R9: a result appears only for a request made one cycle earlier
   a_r9_result_has_request: assert property (@(posedge clk) disable iff (!rst_n)
      (pass_vld || swallow) |-> $past(wr_req));

   // R9: never both outcomes for one request
   a_r9_single_outcome: assert property (@(posedge clk) disable iff (!rst_n)
      !(pass_vld && swallow));
endmodule

// File: rtl/wp_unlock_gate.sv
module wp_unlock_gate
   import wp_unlock_pkg::*;
#(
   parameter int ADDR_W   = 15,
   parameter int DATA_W   = 8,
   parameter int KEY_BITS = 15
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_req,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              win_expire,
   input  logic              page_closed,
   output logic              unlocked,
   output logic [1:0]        prot_stage,
   output logic              pass_vld,
   output logic [ADDR_W-1:0] pass_addr,
   output logic [DATA_W-1:0] pass_data,
   output logic              swallow
);
   initial begin
      if (ADDR_W < 15) $error("wp_unlock_gate: key addresses need ADDR_W of at least 15");
   end

   logic   h1, h2, h3, fwd;
   stage_t stage;

   wp_key_match #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .KEY_BITS(KEY_BITS)
   ) u_match (
      .addr(wr_addr), .data(wr_data), .hit1(h1), .hit2(h2), .hit3(h3)
   );

   wp_seq_fsm u_fsm (
      .clk(clk), .rst_n(rst_n), .wr_req(wr_req),
      .hit1(h1), .hit2(h2), .hit3(h3),
      .win_expire(win_expire), .page_closed(page_closed),
      .stage(stage), .fwd(fwd)
   );

   wp_fwd_reg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fwd (
      .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .fwd(fwd),
      .addr(wr_addr), .data(wr_data),
      .pass_vld(pass_vld), .pass_addr(pass_addr), .pass_data(pass_data),
      .swallow(swallow)
   );

   assign prot_stage = stage;
   assign unlocked   = (stage == ST_OPEN);

   // R6: a forwarded write implies the gate was open when it arrived
   a_r6_pass_only_open: assert property (@(posedge clk) disable iff (!rst_n)
      pass_vld |-> ($past(prot_stage) == 2'd3));

   // R5: a request while not open never forwards
   a_r5_locked_no_pass: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_req && !unlocked) |=> !pass_vld);
endmodule

// File: tb/tb_wp_unlock_gate.sv
module tb_wp_unlock_gate;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        wr_req, win_expire, page_closed;
   logic [14:0] wr_addr;
   logic [7:0]  wr_data;
   logic        unlocked, pass_vld, swallow;
   logic [1:0]  prot_stage;
   logic [14:0] pass_addr;
   logic [7:0]  pass_data;

   int checks = 0;
   int fails  = 0;
   int model_st = 0;
   logic [23:0] expq[$];   // {is_pass, addr[14:0], data[7:0]}

   always #5 clk = ~clk;

   wp_unlock_gate dut (
      .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .wr_addr(wr_addr),
      .wr_data(wr_data), .win_expire(win_expire), .page_closed(page_closed),
      .unlocked(unlocked), .prot_stage(prot_stage), .pass_vld(pass_vld),
      .pass_addr(pass_addr), .pass_data(pass_data), .swallow(swallow)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // monitor: compares every produced result against the scoreboard
   always begin
      @(posedge clk);
      #2;
      if (rst_n && (pass_vld || swallow)) begin
         if (expq.size() == 0) begin
            chk("R9 unexpected output", {30'd0, pass_vld, swallow}, 32'd0);
         end else begin
            logic [23:0] e;
            e = expq.pop_front();
            chk("R9 outcome kind", {31'd0, pass_vld}, {31'd0, e[23]});
            if (e[23]) begin
               chk("R6 forwarded addr", {17'd0, pass_addr}, {17'd0, e[22:8]});
               chk("R6 forwarded data", {24'd0, pass_data}, {24'd0, e[7:0]});
            end
         end
      end
   end

   // driver: one cycle of stimulus, model update, stage check
   task automatic op(input logic rq, input logic [14:0] a, input logic [7:0] d,
                     input logic ex, input logic cl, input string req);
      logic pass;
      int   nx;
      @(negedge clk);
      wr_req = rq; wr_addr = a; wr_data = d; win_expire = ex; page_closed = cl;
      pass = 1'b0;
      nx   = model_st;
      if (ex || cl) nx = 0;
      else if (rq) begin
         case (model_st)
            0: nx = (a == 15'h5555 && d == 8'hAA) ? 1 : 0;
            1: nx = (a == 15'h2AAA && d == 8'h55) ? 2 : 0;
            2: nx = (a == 15'h5555 && d == 8'hA0) ? 3 : 0;
            default: begin nx = 3; pass = 1'b1; end
         endcase
      end
      if (rq) expq.push_back({pass, a, d});
      model_st = nx;
      @(posedge clk);
      #4;
      wr_req = 1'b0; win_expire = 1'b0; page_closed = 1'b0;
      chk({req, " stage"}, {30'd0, prot_stage}, model_st);
      chk("R2 unlocked flag", {31'd0, unlocked}, {31'd0, (model_st == 3)});
      chk("R9 result consumed", expq.size(), 0);
   endtask

   task automatic unlock_seq();
      op(1, 15'h5555, 8'hAA, 0, 0, "R3");
      op(1, 15'h2AAA, 8'h55, 0, 0, "R4");
      op(1, 15'h5555, 8'hA0, 0, 0, "R4");
   endtask

   initial begin
      #1_000_000;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      rst_n = 1'b0; wr_req = 1'b0; win_expire = 1'b0; page_closed = 1'b0;
      wr_addr = '0; wr_data = '0;
      repeat (3) @(posedge clk);
      #2;
      chk("R1 reset stage", {30'd0, prot_stage}, 0);
      chk("R1 reset unlocked", {31'd0, unlocked}, 0);
      chk("R1 reset pass_vld", {31'd0, pass_vld}, 0);
      chk("R1 reset swallow", {31'd0, swallow}, 0);
      @(negedge clk);
      rst_n = 1'b1;

      op(1, 15'h0100, 8'h12, 0, 0, "R5 stray write");
      op(0, 15'h0, 8'h0, 0, 0, "R9 idle");
      unlock_seq();
      op(1, 15'h0123, 8'h3E, 0, 0, "R6");
      op(1, 15'h0124, 8'h7F, 0, 0, "R6");
      op(1, 15'h5555, 8'hAA, 0, 0, "R6 key-like data");
      op(0, 15'h0, 8'h0, 0, 1, "R8 page close");
      op(1, 15'h0125, 8'h01, 0, 0, "R5 after close");

      unlock_seq();
      op(1, 15'h0200, 8'h44, 1, 0, "R7 expire with write");
      op(1, 15'h5555, 8'hAA, 0, 0, "R3");
      op(0, 15'h0, 8'h0, 1, 0, "R7 expire alone");

      op(1, 15'h5555, 8'hAA, 0, 0, "R3");
      op(1, 15'h2AAB, 8'h55, 0, 0, "R5 wrong addr");
      op(1, 15'h5555, 8'hAA, 0, 0, "R3");
      op(1, 15'h2AAA, 8'h55, 0, 0, "R4");
      op(1, 15'h5555, 8'hA1, 0, 0, "R5 wrong data");
      op(1, 15'h5555, 8'hAA, 0, 0, "R3");
      op(1, 15'h5555, 8'hAA, 0, 0, "R5 repeated key");

      unlock_seq();
      op(1, 15'h7FFF, 8'hFF, 0, 1, "R8 close with write");
      op(1, 15'h0300, 8'h5A, 0, 0, "R5 relocked");
      unlock_seq();
      op(1, 15'h0000, 8'h00, 0, 0, "R6 zero write");
      repeat (3) op(0, 15'h0, 8'h0, 0, 0, "R9 idle");

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule